// File: doc/BRIEF.md
# Framebuffer Scanout Pixel Serializer

This block turns a monochrome framebuffer, one bit per pixel and packed eight pixels to a byte, into the serial pixel stream of a composite video line. A separate timing generator handles sync and porches. At the start of each visible line it pulses `line_go`. The serializer then fetches one line of bytes from a byte-wide synchronous memory and shifts each byte out on `pix_out`. Each pixel is held for a fixed number of clocks. The low bit of each byte is shown first.

A single read pointer walks through the whole frame in address order. Lines follow one another in memory with no stride and no per-line rewind. The pointer returns to the frame base only when the timing generator pulses `frame_start`. The next byte is fetched while the last pixel of the current byte is on the output, so consecutive bytes join without a gap. When no line is in progress, the block issues no memory reads and holds the video output low.

The defaults give a line of 52 bytes (416 pixels) at 3 clocks per pixel, which is 1248 clocks per line. The frame base is 0x0100. A frame of 304 lines ends just below 0x3EC0.

Top module: `fb_scanout`

## Requirements
- R1: While reset is held, and after it is released with no `line_go`, `pix_out` and `mem_rd` are both 0.
- R2: When `line_go` is sampled high by an idle block, `mem_rd` is high in the next cycle. The first pixel of the line appears on `pix_out` two cycles after that read cycle.
- R3: Each byte produces 8 pixels. The first pixel is bit 0, the next is bit 1, and so on up to bit 7. Each pixel is held on `pix_out` for exactly 3 clocks, so one byte lasts 24 clocks.
- R4: One line issues exactly 52 reads, each `mem_rd` lasting one cycle, spaced exactly 24 cycles apart. Each byte's pixels follow the previous byte's with no idle cycle between them.
- R5: The address of each read is one more than the address of the previous read. This holds within a line and from the last byte of one line to the first byte of the next.
- R6: After reset, or after `frame_start` has been sampled high, the next read uses address 0x0100. This also applies when `frame_start` and `line_go` are sampled in the same cycle.
- R7: `pix_out` is 0 whenever no pixel is on the output: before the first pixel of a line and from the cycle after the 416th pixel onward.
- R8: A `line_go` pulse that arrives while a line is in progress is ignored. It adds no reads and does not disturb the addresses or the pixels of that line.
- R9: Between lines, `mem_rd` stays low. A `frame_start` pulse on its own issues no read.
- R10: Read data is taken only in the cycle right after the `mem_rd` cycle. The value on `mem_rdata` at any other time has no effect on `pix_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | One-cycle pulse that returns the read pointer to the frame base |
| line_go | input | 1 | One-cycle pulse that opens the visible part of a line |
| mem_addr | output | 16 | Byte address of the current read |
| mem_rd | output | 1 | Read strobe, one cycle per byte |
| mem_rdata | input | 8 | Read data, valid in the cycle after `mem_rd` |
| pix_out | output | 1 | Serial pixel output, low when no pixel is on the output |

## Verification
Counting from the clock edge that samples `line_go`, read k (starting at 0) is visible 24·k cycles after that edge, and pixel p of the line is on the output 2 + 3·p cycles after it. Every result therefore has a fixed arrival cycle. The bench counts falling edges from the `line_go` edge and compares `mem_rd`, `mem_addr` and `pix_out` at each one against values worked out from those offsets. The bench memory answers one edge after the strobe and drives the inverse of the expected byte at all other times. A design that captures data a cycle early or late therefore shows inverted pixels instead of passing by chance.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;

  // Offset of a pixel phase inside one byte's display time.
  function automatic int unsigned pix_pos(input int unsigned bit_i,
                                          input int unsigned phase,
                                          input int unsigned cpp);
    return bit_i * cpp + phase;
  endfunction

  // Offset at which the next read must be issued. Two registers lie
  // between the strobe and the shift load, so the strobe goes out
  // two clocks before the current byte ends.
  function automatic int unsigned prefetch_pos(input int unsigned cpp,
                                               input int unsigned ppb);
    return ppb * cpp - 3;
  endfunction

  // Clocks taken by one byte on the output.
  function automatic int unsigned byte_clocks(input int unsigned cpp,
                                              input int unsigned ppb);
    return ppb * cpp;
  endfunction

  // Width of a counter that must hold values 0..n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/fbscan_addr_gen.sv
module fbscan_addr_gen #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              issue,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd
);

  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] ptr_eff;
  logic [ADDR_W-1:0] ptr_next;

  // A frame restart seen in the same cycle as a read wins: the read
  // goes to the base address.
  always_comb begin
    ptr_eff  = frame_start ? BASE_ADDR : ptr_q;
    ptr_next = ptr_eff + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= BASE_ADDR;
      mem_addr <= '0;
      mem_rd   <= 1'b0;
    end else begin
      mem_rd <= issue;
      if (issue) begin
        mem_addr <= ptr_eff;
        ptr_q    <= ptr_next;
      end else if (frame_start) begin
        ptr_q <= BASE_ADDR;
      end
    end
  end

endmodule

// File: rtl/fbscan_line_ctl.sv
module fbscan_line_ctl #(
  parameter int LINE_BYTES = 52
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_go,
  input  logic prefetch_slot,
  input  logic byte_end,
  output logic issue,
  output logic line_busy
);

  localparam int CNT_W = fbscan_pkg::cnt_width(LINE_BYTES);

  logic [CNT_W-1:0] issued_q;
  logic [CNT_W-1:0] shown_q;
  logic             start;
  logic             more_to_fetch;
  logic             last_byte_out;

  always_comb begin
    start         = line_go && !line_busy;
    more_to_fetch = issued_q != CNT_W'(LINE_BYTES);
    last_byte_out = byte_end && (shown_q == CNT_W'(LINE_BYTES - 1));
    issue         = start || (line_busy && prefetch_slot && more_to_fetch);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_busy <= 1'b0;
      issued_q  <= '0;
      shown_q   <= '0;
    end else if (start) begin
      line_busy <= 1'b1;
      issued_q  <= CNT_W'(1);
      shown_q   <= '0;
    end else if (line_busy) begin
      if (issue) begin
        issued_q <= issued_q + CNT_W'(1);
      end
      if (last_byte_out) begin
        line_busy <= 1'b0;
      end else if (byte_end) begin
        shown_q <= shown_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/fbscan_shifter.sv
module fbscan_shifter #(
  parameter int DATA_W       = 8,
  parameter int CLKS_PER_PIX = 3,
  parameter bit LSB_FIRST    = 1'b1,
  localparam int PH_W = (CLKS_PER_PIX > 1) ? $clog2(CLKS_PER_PIX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_seen,
  input  logic [DATA_W-1:0] rdata,
  output logic              pix,
  output logic              shown,
  output logic [PH_W-1:0]   phase,
  output logic              byte_end,
  output logic              prefetch_slot
);

  localparam int BIT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int POS_W    = fbscan_pkg::cnt_width(
                              fbscan_pkg::byte_clocks(CLKS_PER_PIX, DATA_W));
  localparam int PREF_POS = fbscan_pkg::prefetch_pos(CLKS_PER_PIX, DATA_W);

  logic              load_q;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] shreg_next;
  logic              head_bit;
  logic [BIT_W-1:0]  bitn;
  logic              phase_last;
  logic              bit_last;
  logic [POS_W-1:0]  pos;

  generate
    if (LSB_FIRST) begin : g_lsb
      assign shreg_next = shreg >> 1;
      assign head_bit   = shreg[0];
    end else begin : g_msb
      assign shreg_next = shreg << 1;
      assign head_bit   = shreg[DATA_W-1];
    end
  endgenerate

  always_comb begin
    phase_last    = phase == PH_W'(CLKS_PER_PIX - 1);
    bit_last      = bitn == BIT_W'(DATA_W - 1);
    pos           = POS_W'(fbscan_pkg::pix_pos(int'(bitn), int'(phase), CLKS_PER_PIX));
    byte_end      = shown && bit_last && phase_last;
    prefetch_slot = shown && (pos == POS_W'(PREF_POS));
    pix           = shown && head_bit;
  end

  // Read data is valid in the cycle after the strobe; load it then.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b0;
    end else begin
      load_q <= rd_seen;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      shown <= 1'b0;
      phase <= '0;
      bitn  <= '0;
    end else if (load_q) begin
      shreg <= rdata;
      shown <= 1'b1;
      phase <= '0;
      bitn  <= '0;
    end else if (shown) begin
      if (phase_last) begin
        phase <= '0;
        if (bit_last) begin
          shown <= 1'b0;
        end else begin
          bitn  <= bitn + BIT_W'(1);
          shreg <= shreg_next;
        end
      end else begin
        phase <= phase + PH_W'(1);
      end
    end
  end

endmodule

// File: rtl/fb_scanout.sv
module fb_scanout #(
  parameter int                ADDR_W       = 16,
  parameter int                DATA_W       = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR    = 16'h0100,
  parameter int                LINE_BYTES   = 52,
  parameter int                CLKS_PER_PIX = 3,
  parameter bit                LSB_FIRST    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_go,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              pix_out
);

  localparam int PH_W = (CLKS_PER_PIX > 1) ? $clog2(CLKS_PER_PIX) : 1;

  // Internal events, named so the checker can observe them.
  logic            issue;
  logic            line_busy;
  logic            pix_shown;
  logic [PH_W-1:0] pix_phase;
  logic            byte_end;
  logic            prefetch_slot;

  fbscan_line_ctl #(
    .LINE_BYTES (LINE_BYTES)
  ) u_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_go       (line_go),
    .prefetch_slot (prefetch_slot),
    .byte_end      (byte_end),
    .issue         (issue),
    .line_busy     (line_busy)
  );

  fbscan_addr_gen #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .issue       (issue),
    .mem_addr    (mem_addr),
    .mem_rd      (mem_rd)
  );

  fbscan_shifter #(
    .DATA_W       (DATA_W),
    .CLKS_PER_PIX (CLKS_PER_PIX),
    .LSB_FIRST    (LSB_FIRST)
  ) u_shift (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_seen       (mem_rd),
    .rdata         (mem_rdata),
    .pix           (pix_out),
    .shown         (pix_shown),
    .phase         (pix_phase),
    .byte_end      (byte_end),
    .prefetch_slot (prefetch_slot)
  );

endmodule

// File: rtl/fb_scanout_chk.sv
module fb_scanout_chk #(
  parameter int                ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR    = 16'h0100,
  parameter int                LINE_BYTES   = 52,
  parameter int                PH_W         = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              pix_out,
  input logic              line_busy,
  input logic              pix_shown,
  input logic [PH_W-1:0]   pix_phase
);

  localparam int CNT_W = fbscan_pkg::cnt_width(LINE_BYTES);

  logic [ADDR_W-1:0] last_addr;
  logic              restart_pend;
  logic              have_prev;
  logic [CNT_W-1:0]  rd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_addr    <= '0;
      restart_pend <= 1'b1;
      have_prev    <= 1'b0;
      rd_cnt       <= '0;
    end else begin
      if (mem_rd) begin
        last_addr <= mem_addr;
        have_prev <= 1'b1;
      end
      if (frame_start)  restart_pend <= 1'b1;
      else if (mem_rd)  restart_pend <= 1'b0;
      if (!line_busy)   rd_cnt <= '0;
      else if (mem_rd)  rd_cnt <= rd_cnt + CNT_W'(1);
    end
  end

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd); // R4

  AST_RD_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> line_busy); // R9

  AST_FIRST_PIX_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_shown) |-> $past(mem_rd, 2)); // R2

  AST_PIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_shown && $past(pix_shown) && pix_phase != '0) |-> $stable(pix_out)); // R3

  AST_DARK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !line_busy |-> !pix_out); // R7

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && have_prev && !restart_pend) |-> mem_addr == last_addr + ADDR_W'(1)); // R5

  AST_ADDR_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && restart_pend) |-> mem_addr == BASE_ADDR); // R6

  AST_LINE_READS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_busy) |-> rd_cnt == CNT_W'(LINE_BYTES)); // R4

endmodule

bind fb_scanout fb_scanout_chk #(
  .ADDR_W     (ADDR_W),
  .BASE_ADDR  (BASE_ADDR),
  .LINE_BYTES (LINE_BYTES),
  .PH_W       (PH_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .mem_rd      (mem_rd),
  .mem_addr    (mem_addr),
  .pix_out     (pix_out),
  .line_busy   (line_busy),
  .pix_shown   (pix_shown),
  .pix_phase   (pix_phase)
);

// File: tb/fb_scanout_tb.sv
`timescale 1ns/1ps
module fb_scanout_tb;

  localparam int NBYTES = 52;
  localparam int CPP    = 3;
  localparam int BCLK   = 8 * CPP;
  localparam int LINE_N = NBYTES * BCLK;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic        line_go = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_rdata = 8'h00;
  logic        pix_out;
  logic [7:0]  key = 8'h00;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  fb_scanout u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .line_go     (line_go),
    .mem_addr    (mem_addr),
    .mem_rd      (mem_rd),
    .mem_rdata   (mem_rdata),
    .pix_out     (pix_out)
  );

  function automatic logic [7:0] pat(input logic [15:0] a, input logic [7:0] k);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ k;
  endfunction

  // Synchronous memory: answers one edge after the strobe; otherwise
  // drives the inverse so that a mistimed capture shows up (R10).
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= pat(mem_addr, key);
    else        mem_rdata <= ~pat(mem_addr, key);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(pix_out == 1'b0 && mem_rd == 1'b0, "R1", "in reset pix|rd", {pix_out, mem_rd}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(pix_out == 1'b0 && mem_rd == 1'b0, "R1", "after reset pix|rd", {pix_out, mem_rd}, 0);
  endtask

  // One visible line. n counts falling edges after the line_go edge.
  task automatic t_line(input bit fs_same, input bit extra_go,
                        input logic [15:0] base, input logic [7:0] k);
    int rd_cnt = 0, rd_bad = 0, ad_bad = 0, px_bad = 0, dk_bad = 0, gap_bad = 0;
    int ad_act = 0, ad_exp = 0, px_n = 0, go_bad = 0;
    @(negedge clk);
    key = k;
    line_go = 1'b1;
    frame_start = fs_same;
    @(negedge clk);
    line_go = 1'b0;
    frame_start = 1'b0;
    for (int n = 0; n < LINE_N + 12; n++) begin
      bit exp_rd = (n % BCLK == 0) && (n / BCLK < NBYTES);
      logic [15:0] exp_a = base + 16'(n / BCLK);
      bit in_px = (n >= 2) && (n < LINE_N + 2);
      bit exp_px = 1'b0;
      if (in_px) begin
        logic [7:0] b = pat(base + 16'((n - 2) / BCLK), k);
        exp_px = b[((n - 2) % BCLK) / CPP];
      end
      if (mem_rd) rd_cnt++;
      if (mem_rd != exp_rd) begin
        rd_bad++;
        if (extra_go && n > 600 && n < 630) go_bad++;
      end
      if (exp_rd && mem_rd && mem_addr != exp_a) begin
        if (ad_bad == 0) begin ad_act = mem_addr; ad_exp = exp_a; end
        ad_bad++;
      end
      if (in_px && pix_out != exp_px) begin
        if (px_bad == 0) px_n = n;
        px_bad++;
      end
      if (!in_px && pix_out != 1'b0) dk_bad++;
      line_go = (extra_go && n == 600);
      @(negedge clk);
    end
    line_go = 1'b0;
    for (int g = 0; g < 20; g++) begin
      if (mem_rd || pix_out) gap_bad++;
      @(negedge clk);
    end
    chk(rd_bad == 0, "R2", "read strobe timing mismatches", rd_bad, 0);
    chk(rd_cnt == NBYTES, "R4", "reads per line", rd_cnt, NBYTES);
    chk(ad_bad == 0, (base == 16'h0100) ? "R6" : "R5", "read address", ad_act, ad_exp);
    chk(px_bad == 0, "R3", "pixel mismatches (first at n)", px_bad, 0);
    if (px_bad != 0) $display("  first bad pixel at offset %0d", px_n);
    chk(px_bad == 0, "R10", "pixels from strobe-cycle data only", px_bad, 0);
    chk(dk_bad == 0, "R7", "pixels outside window", dk_bad, 0);
    chk(gap_bad == 0, "R9", "activity between lines", gap_bad, 0);
    if (extra_go) chk(go_bad == 0 && rd_cnt == NBYTES, "R8", "mid-line line_go effect", go_bad, 0);
  endtask

  task automatic t_restart_alone();
    int bad = 0;
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (mem_rd || pix_out) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R9", "frame_start alone issued activity", bad, 0);
  endtask

  initial begin
    t_reset();
    t_line(1'b0, 1'b0, 16'h0100, 8'h5A);
    t_line(1'b0, 1'b1, 16'h0100 + 16'(NBYTES), 8'hC3);
    t_restart_alone();
    t_line(1'b0, 1'b0, 16'h0100, 8'h0F);
    t_line(1'b1, 1'b0, 16'h0100, 8'hF0);
    t_line(1'b0, 1'b0, 16'h0100 + 16'(NBYTES), 8'h96);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule